// File: doc/BRIEF.md
# Input Clock and Frame-Sync Loss Monitor

This block supervises a set of externally supplied clocks and frame-sync pulses from inside a free-running reference clock domain, which in practice is the processor clock. Every monitored signal first passes through a two-flop synchronizer and then feeds an activity timer. A monitored clock counts as lost once it has shown no edge, rising or falling, for a programmed number of reference cycles. That covers both stuck-high and stuck-low failures. The default of 7500 cycles gives about 60 µs at 125 MHz, which sits well inside the required band of more than 10 µs and less than 125 µs. A sync input counts as lost when no rising pulse has arrived within a set number of expected frame periods. It recovers on the next pulse.

Each monitored signal has three bits: a live loss status bit, a sticky change bit and an interrupt mask bit. The change bit records every change of the status bit, whether entering or leaving loss. Software clears a change bit by writing 1 to it. The single interrupt output is raised while any change bit is set and its mask bit is 0.

Top module: `clk_sync_loss_mon`

## Requirements
- R1: After reset, every status bit and every change bit is 0, every mask bit is 1 and the interrupt output is 0.
- R2: A monitored clock that keeps toggling with a gap shorter than CLK_TIMEOUT reference cycles keeps its status bit at 0. Its status bit stays 0 during the first part of a stop, well below CLK_TIMEOUT cycles.
- R3: The status bit of a lost clock returns to 0 after the clock toggles again.
- R4: The status bit of a sync input is set once no rising pulse has been seen for SYNC_FRAME_CYC*SYNC_MISS_FRAMES reference cycles. It is not set earlier than that, and it clears on the next rising pulse.
- R5: Every change of a status bit, from 0 to 1 or from 1 to 0, sets the matching change bit. The change bit then stays set until it is cleared.
- R6: A write with wr_addr_i = 0 clears each change bit whose wr_data_i bit is 1. Change bits whose wr_data_i bit is 0 are left unchanged.
- R7: A write with wr_addr_i = 1 loads wr_data_i into the mask bits, and no other event changes them. The registered irq_o equals the OR of (change AND NOT mask).
- R8: Bit i of stat_o, delta_o and mask_o, for i below N_CLK, belongs to mon_clk_i[i]. Bit N_CLK+j belongs to mon_sync_i[j].
- R9: A clock is detected as lost whether it is stuck at 1 or stuck at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Free-running reference clock used to time all windows |
| rst_ref_ni | input | 1 | Active-low reset, reference domain |
| mon_clk_i | input | N_CLK | Monitored clocks, asynchronous |
| mon_sync_i | input | N_SYNC | Monitored frame-sync pulses, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = clear change bits (write 1 to clear), 1 = load mask |
| wr_data_i | input | N_CLK+N_SYNC | Write data, bit layout as in R8 |
| stat_o | output | N_CLK+N_SYNC | Live loss status |
| delta_o | output | N_CLK+N_SYNC | Sticky change bits |
| mask_o | output | N_CLK+N_SYNC | Interrupt mask bits |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is a clock or sync that is stopped for only part of its window. It must stay reported as healthy during that stretch and then flip to lost once the window has run out. The bench keeps a global cycle counter and drives every monitored signal from it with a fixed toggle period and a fixed frame period. Because of this, the time since the last edge is known exactly when a signal is held. The bench then samples once well inside the window and once well past it. It stops one clock at 0 and another at 1, and it sends a write-1-to-clear with a zero bit over a set change bit, to show that such a bit is left alone.

// File: rtl/lossmon_pkg.sv
package lossmon_pkg;
    typedef enum logic {
        ADDR_DELTA_CLR = 1'b0,
        ADDR_MASK      = 1'b1
    } reg_addr_e;
endpackage

// File: rtl/lossmon_sync2.sv
module lossmon_sync2 #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/lossmon_activity_timer.sv
module lossmon_activity_timer #(
    parameter int LIMIT    = 7500,
    parameter bit ANY_EDGE = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic lost_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          lost;
    } st_t;

    st_t  st_d, st_q;
    logic act;

    // Activity event: any edge for clocks, rising edge for sync pulses
    generate
        if (ANY_EDGE) begin : g_any
            assign act = sig_i ^ st_q.prev;
        end else begin : g_rise
            assign act = sig_i & ~st_q.prev;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
        if (act) begin
            st_d.cnt  = '0;
            st_d.lost = 1'b0;
        end else if (st_q.cnt == CW'(LIMIT)) begin
            st_d.lost = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lost_o = st_q.lost;
endmodule

// File: rtl/lossmon_event_bank.sv
module lossmon_event_bank
    import lossmon_pkg::*;
#(
    parameter int N = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] lost_i,
    input  logic         wr_en_i,
    input  logic         wr_addr_i,
    input  logic [N-1:0] wr_data_i,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] delta_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] stat;
        logic [N-1:0] delta;
        logic [N-1:0] mask;
        logic         irq;
    } st_t;

    st_t          st_d, st_q;
    reg_addr_e    addr;
    logic [N-1:0] clr;

    assign addr = reg_addr_e'(wr_addr_i);

    always_comb begin
        st_d       = st_q;
        clr        = (wr_en_i && addr == ADDR_DELTA_CLR) ? wr_data_i : '0;
        st_d.stat  = lost_i;
        // a fresh change wins over a clear in the same cycle
        st_d.delta = (st_q.delta & ~clr) | (lost_i ^ st_q.stat);
        if (wr_en_i && addr == ADDR_MASK) st_d.mask = wr_data_i;
        st_d.irq   = |(st_d.delta & ~st_d.mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.stat  <= '0;
            st_q.delta <= '0;
            st_q.mask  <= '1;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o  = st_q.stat;
    assign delta_o = st_q.delta;
    assign mask_o  = st_q.mask;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/clk_sync_loss_mon.sv
module clk_sync_loss_mon #(
    parameter int N_CLK            = 3,
    parameter int N_SYNC           = 4,
    parameter int CLK_TIMEOUT      = 7500,
    parameter int SYNC_FRAME_CYC   = 15625,
    parameter int SYNC_MISS_FRAMES = 4
) (
    input  logic                     clk_ref_i,
    input  logic                     rst_ref_ni,
    input  logic [N_CLK-1:0]         mon_clk_i,
    input  logic [N_SYNC-1:0]        mon_sync_i,
    input  logic                     wr_en_i,
    input  logic                     wr_addr_i,
    input  logic [N_CLK+N_SYNC-1:0]  wr_data_i,
    output logic [N_CLK+N_SYNC-1:0]  stat_o,
    output logic [N_CLK+N_SYNC-1:0]  delta_o,
    output logic [N_CLK+N_SYNC-1:0]  mask_o,
    output logic                     irq_o
);
    localparam int N_SIG       = N_CLK + N_SYNC;
    localparam int SYNC_WINDOW = SYNC_FRAME_CYC * SYNC_MISS_FRAMES;

    logic [N_SIG-1:0] raw_all;
    logic [N_SIG-1:0] synced;
    logic [N_SIG-1:0] lost;

    assign raw_all = {mon_sync_i, mon_clk_i};

    lossmon_sync2 #(.W(N_SIG)) u_sync (
        .clk_i  (clk_ref_i),
        .rst_ni (rst_ref_ni),
        .async_i(raw_all),
        .sync_o (synced)
    );

    generate
        for (genvar i = 0; i < N_SIG; i++) begin : g_watch
            if (i < N_CLK) begin : g_clk
                lossmon_activity_timer #(.LIMIT(CLK_TIMEOUT), .ANY_EDGE(1'b1)) u_tmr (
                    .clk_i (clk_ref_i),
                    .rst_ni(rst_ref_ni),
                    .sig_i (synced[i]),
                    .lost_o(lost[i])
                );
            end else begin : g_frm
                lossmon_activity_timer #(.LIMIT(SYNC_WINDOW), .ANY_EDGE(1'b0)) u_tmr (
                    .clk_i (clk_ref_i),
                    .rst_ni(rst_ref_ni),
                    .sig_i (synced[i]),
                    .lost_o(lost[i])
                );
            end
        end
    endgenerate

    lossmon_event_bank #(.N(N_SIG)) u_bank (
        .clk_i    (clk_ref_i),
        .rst_ni   (rst_ref_ni),
        .lost_i   (lost),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .stat_o   (stat_o),
        .delta_o  (delta_o),
        .mask_o   (mask_o),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/lossmon_checker.sv
module lossmon_checker #(
    parameter int N = 7
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         wr_en_i,
    input logic         wr_addr_i,
    input logic [N-1:0] wr_data_i,
    input logic [N-1:0] stat_i,
    input logic [N-1:0] delta_i,
    input logic [N-1:0] mask_i,
    input logic         irq_i
);
    p_mask_reset_r1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (mask_i == '1 && delta_i == '0));

    p_delta_tracks_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat_i ^ $past(stat_i)) & ~delta_i) == '0);

    p_irq_matches_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i == |(delta_i & ~mask_i));

    p_mask_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i) |=> $stable(mask_i));

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            p_delta_w1c_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $fell(delta_i[i]) |-> $past(wr_en_i && !wr_addr_i && wr_data_i[i]));
        end
    endgenerate
endmodule

bind clk_sync_loss_mon lossmon_checker #(.N(N_CLK + N_SYNC)) u_chk (
    .clk_i    (clk_ref_i),
    .rst_ni   (rst_ref_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .stat_i   (stat_o),
    .delta_i  (delta_o),
    .mask_i   (mask_o),
    .irq_i    (irq_o)
);

// File: tb/clk_sync_loss_mon_bench.sv
module clk_sync_loss_mon_bench;
    localparam int NC = 3;
    localparam int NS = 4;
    localparam int NT = NC + NS;
    localparam int TOGGLE = 5;
    localparam int FRAME  = 16;

    typedef struct {
        string         req;
        logic [NT-1:0] stat;
        logic [NT-1:0] delta;
        logic [NT-1:0] mask;
        logic          irq;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] mclk = '0;
    logic [NS-1:0] msync = '0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [NT-1:0] wr_data = '0;
    logic [NT-1:0] stat, delta, mask;
    logic          irq;

    logic [NC-1:0] clk_run  = '1;
    logic [NS-1:0] sync_run = '1;
    int            cyc = 0;
    int            checks = 0;
    int            fails = 0;
    bit            done = 1'b0;
    item_t         sb_q[$];

    always #4 clk = ~clk;

    clk_sync_loss_mon #(
        .N_CLK(NC), .N_SYNC(NS), .CLK_TIMEOUT(40),
        .SYNC_FRAME_CYC(FRAME), .SYNC_MISS_FRAMES(3)
    ) u_clk_sync_loss_mon (
        .clk_ref_i (clk),
        .rst_ref_ni(rst_n),
        .mon_clk_i (mclk),
        .mon_sync_i(msync),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .stat_o    (stat),
        .delta_o   (delta),
        .mask_o    (mask),
        .irq_o     (irq)
    );

    task automatic tick();
        @(negedge clk);
        if (cyc % TOGGLE == 0) mclk = mclk ^ clk_run;
        msync = (cyc % FRAME == 0) ? sync_run : '0;
        cyc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic a, logic [NT-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic expect_now(string req, logic [NT-1:0] s, logic [NT-1:0] d,
                              logic [NT-1:0] m, logic i);
        item_t it;
        it.req = req; it.stat = s; it.delta = d; it.mask = m; it.irq = i;
        sb_q.push_back(it);
    endtask

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            #1;
            it = sb_q.pop_front();
            checks++;
            if (stat !== it.stat || delta !== it.delta || mask !== it.mask || irq !== it.irq) begin
                fails++;
                $display("FAIL %s: stat=%h delta=%h mask=%h irq=%b expected stat=%h delta=%h mask=%h irq=%b",
                         it.req, stat, delta, mask, irq, it.stat, it.delta, it.mask, it.irq);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        tick();
        expect_now("R1 reset", 7'h00, 7'h00, 7'h7f, 1'b0);
        run(200);
        expect_now("R2 all toggling", 7'h00, 7'h00, 7'h7f, 1'b0);
        wr(1'b1, 7'h00);
        expect_now("R7 mask load", 7'h00, 7'h00, 7'h00, 1'b0);

        // R9: clock 1 held at 0
        mclk[1] = 1'b0; clk_run = 3'b101;
        run(20);
        expect_now("R2 inside window", 7'h00, 7'h00, 7'h00, 1'b0);
        run(200);
        expect_now("R9 R8 stuck low", 7'h02, 7'h02, 7'h00, 1'b1);
        wr(1'b0, 7'h01);
        expect_now("R6 zero bit keeps", 7'h02, 7'h02, 7'h00, 1'b1);
        wr(1'b0, 7'h02);
        expect_now("R6 w1c clears", 7'h02, 7'h00, 7'h00, 1'b0);

        clk_run = 3'b111;
        run(50);
        expect_now("R3 R5 recovery", 7'h00, 7'h02, 7'h00, 1'b1);
        wr(1'b1, 7'h02);
        expect_now("R7 masked", 7'h00, 7'h02, 7'h02, 1'b0);
        wr(1'b0, 7'h02);
        wr(1'b1, 7'h00);

        // sync input 2 -> bit 5
        sync_run = 4'b1011;
        run(30);
        expect_now("R4 before window", 7'h00, 7'h00, 7'h00, 1'b0);
        run(150);
        expect_now("R4 R8 sync lost", 7'h20, 7'h20, 7'h00, 1'b1);
        sync_run = 4'b1111;
        run(40);
        expect_now("R4 R5 sync back", 7'h00, 7'h20, 7'h00, 1'b1);
        wr(1'b0, 7'h20);

        // R9: clock 0 held at 1
        mclk[0] = 1'b1; clk_run = 3'b110;
        run(150);
        expect_now("R9 stuck high", 7'h01, 7'h01, 7'h00, 1'b1);

        run(3);
        wait (sb_q.size() == 0);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule